// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the 32-bit program counter of a simple load-store processor with fixed four-byte instructions and picks the next fetch address every cycle. Decode supplies a transfer-kind code together with the register operands, the sign-extended immediate, the 26-bit jump index and an explicit destination register number. The unit evaluates any branch condition itself. It then chooses between four sources: sequential flow, a PC-relative target in whole words, an absolute target inside the current 256 MB region, and a register-held target.

For the two call kinds it also produces the link write-back: a valid strobe, the register to write and the return address, all in the same cycle the call is presented. An enable input gates every update. A stalled cycle keeps the PC and suppresses the link strobe.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low the PC is loaded with the parameter `BOOT_ADDR`, and `pc_o` shows that value in the cycle after the first clock edge in reset.
- R2: When `en` is low, `pc_o` keeps its value across the clock edge and `link_we` stays low, whatever the transfer code is.
- R3: Transfer code 0 (sequential) advances the PC by 4. Codes 11 to 15 are unused and also advance by 4, with no link write.
- R4: Code 1 branches when `op_a` equals `op_b`. Code 2 branches when they differ.
- R5: Codes 3, 4, 5 and 6 compare `op_a`, read as a signed number, against zero: greater than, greater or equal, less than, and less or equal.
- R6: A taken branch loads PC+4 plus `imm_ext` shifted left by two, with wrap-around modulo 2^32. A branch that is not taken loads PC+4.
- R7: Code 7 (direct jump) loads bits 31..28 of PC+4, then `jidx`, then two zero bits.
- R8: Code 8 (direct call) makes the same jump as code 7 and, in the cycle it is presented with `en` high, raises `link_we` with `link_reg` = 31 and `link_val` = PC+4.
- R9: Code 9 (register jump) loads `op_a` with its two low bits cleared.
- R10: Code 10 (register call) loads `op_a` with its two low bits cleared and raises `link_we` with `link_reg` = `rd_sel` and `link_val` = PC+4.
- R11: `link_we` is high only for codes 8 and 10 with `en` high. It is never high for branches, plain jumps or sequential flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance enable; low holds the PC |
| kind | input | 4 | Transfer code (0 sequential … 10 register call) |
| op_a | input | 32 | First register operand, also the register target |
| op_b | input | 32 | Second register operand for equality branches |
| imm_ext | input | 32 | Sign-extended 16-bit branch offset in words |
| jidx | input | 26 | Direct jump word index |
| rd_sel | input | 5 | Explicit link destination for the register call |
| pc_o | output | 32 | Current program counter |
| link_we | output | 1 | Link write strobe |
| link_reg | output | 5 | Link destination register number |
| link_val | output | 32 | Return address (PC+4) |

## Verification
The assertions check several rules on every cycle: the PC holds during stalls, it advances by exactly 4 whenever no redirect is chosen, the link strobe appears only for enabled call codes, and the link value and the fixed link register are correct. A branch condition flag is never raised for a non-branch code. Whether each target is the right value can only be shown by the bench. It steers the PC to chosen bases, including one near the top of the address space and one at a region boundary, through register jumps. It then sweeps every code against operand, sign, immediate and index patterns and compares the result with an arithmetic model.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int XLEN   = 32;
  localparam int IDX_W  = 26;
  localparam int REG_W  = 5;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    XF_SEQ  = 4'd0,
    XF_BEQ  = 4'd1,
    XF_BNE  = 4'd2,
    XF_BGTZ = 4'd3,
    XF_BGEZ = 4'd4,
    XF_BLTZ = 4'd5,
    XF_BLEZ = 4'd6,
    XF_JMP  = 4'd7,
    XF_CALL = 4'd8,
    XF_JREG = 4'd9,
    XF_CREG = 4'd10
  } xfer_e;

  // Address of the following instruction.
  function automatic logic [XLEN-1:0] pc_step(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  // Word-scaled relative target from the sequential address.
  function automatic logic [XLEN-1:0] rel_target(input logic [XLEN-1:0] seq,
                                                 input logic [XLEN-1:0] off_words);
    return seq + {off_words[XLEN-3:0], 2'b00};
  endfunction

  // Region-absolute target: top bits of seq, index, two zero bits.
  function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] seq,
                                                    input logic [IDX_W-1:0] idx);
    return {seq[XLEN-1:IDX_W+2], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
    return {a[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic is_cond(input xfer_e k);
    return (k == XF_BEQ) || (k == XF_BNE) || (k == XF_BGTZ) ||
           (k == XF_BGEZ) || (k == XF_BLTZ) || (k == XF_BLEZ);
  endfunction

  function automatic logic is_call(input xfer_e k);
    return (k == XF_CALL) || (k == XF_CREG);
  endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  xfer_e          kind,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           taken
);
  // Equality only: no subtractor. Zero compares use sign bit and zero test.
  logic same;
  logic a_zero;
  logic a_neg;

  assign same   = (op_a == op_b);
  assign a_zero = (op_a == '0);
  assign a_neg  = op_a[W-1];

  always_comb begin
    unique case (kind)
      XF_BEQ:  taken = same;
      XF_BNE:  taken = !same;
      XF_BGTZ: taken = !a_neg && !a_zero;
      XF_BGEZ: taken = !a_neg;
      XF_BLTZ: taken = a_neg;
      XF_BLEZ: taken = a_neg || a_zero;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int W = XLEN,
  parameter int IW = IDX_W
) (
  input  xfer_e          kind,
  input  logic [W-1:0]   seq_pc,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   imm_ext,
  input  logic [IW-1:0]  jidx,
  input  logic           taken,
  output logic [W-1:0]   next_pc,
  output logic           redirect
);
  logic [W-1:0] rel_t;
  logic [W-1:0] abs_t;
  logic [W-1:0] reg_t;

  assign rel_t = rel_target(seq_pc, imm_ext);
  assign abs_t = region_target(seq_pc, jidx);
  assign reg_t = word_align(op_a);

  always_comb begin
    next_pc  = seq_pc;
    redirect = 1'b0;
    case (kind)
      XF_BEQ, XF_BNE, XF_BGTZ, XF_BGEZ, XF_BLTZ, XF_BLEZ: begin
        if (taken) begin
          next_pc  = rel_t;
          redirect = 1'b1;
        end
      end
      XF_JMP, XF_CALL: begin
        next_pc  = abs_t;
        redirect = 1'b1;
      end
      XF_JREG, XF_CREG: begin
        next_pc  = reg_t;
        redirect = 1'b1;
      end
      default: begin
        next_pc  = seq_pc;
        redirect = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int W = XLEN,
  parameter int RW = REG_W,
  parameter logic [RW-1:0] RET_REG = RW'(31)
) (
  input  logic           en,
  input  xfer_e          kind,
  input  logic [W-1:0]   seq_pc,
  input  logic [RW-1:0]  rd_sel,
  output logic           link_we,
  output logic [RW-1:0]  link_reg,
  output logic [W-1:0]   link_val
);
  assign link_we  = en && is_call(kind);
  assign link_reg = (kind == XF_CREG) ? rd_sel : RET_REG;
  assign link_val = seq_pc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0000_1000,
  parameter int              LINK_REG  = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [CODE_W-1:0]  kind,
  input  logic [XLEN-1:0]    op_a,
  input  logic [XLEN-1:0]    op_b,
  input  logic [XLEN-1:0]    imm_ext,
  input  logic [IDX_W-1:0]   jidx,
  input  logic [REG_W-1:0]   rd_sel,
  output logic [XLEN-1:0]    pc_o,
  output logic               link_we,
  output logic [REG_W-1:0]   link_reg,
  output logic [XLEN-1:0]    link_val
);
  localparam logic [REG_W-1:0] RET_REG = REG_W'(LINK_REG);

  xfer_e            k;
  logic [XLEN-1:0]  pc_q;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  next_pc;
  logic             br_taken;
  logic             redirect;

  assign k      = xfer_e'(kind);
  assign seq_pc = pc_step(pc_q);

  npc_cond #(.W(XLEN)) u_cond (
    .kind  (k),
    .op_a  (op_a),
    .op_b  (op_b),
    .taken (br_taken)
  );

  npc_target #(.W(XLEN), .IW(IDX_W)) u_target (
    .kind     (k),
    .seq_pc   (seq_pc),
    .op_a     (op_a),
    .imm_ext  (imm_ext),
    .jidx     (jidx),
    .taken    (br_taken),
    .next_pc  (next_pc),
    .redirect (redirect)
  );

  npc_link #(.W(XLEN), .RW(REG_W), .RET_REG(RET_REG)) u_link (
    .en       (en),
    .kind     (k),
    .seq_pc   (seq_pc),
    .rd_sel   (rd_sel),
    .link_we  (link_we),
    .link_reg (link_reg),
    .link_val (link_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      pc_q <= BOOT_ADDR;
    else if (en)     pc_q <= next_pc;
  end

  assign pc_o = pc_q;

  // Stall keeps the PC.
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc_o));

  // No redirect means a plain four-byte step.
  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !redirect) |=> (pc_o == $past(pc_o) + 32'd4));

  // Condition flag only ever raised for a branch code.
  assert_cond_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> is_cond(k));

  // Link strobe only for enabled calls.
  assert_link_calls_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (en && (kind == 4'd8 || kind == 4'd10)));

  // Direct call writes the fixed return register.
  assert_call_ret_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_we && kind == 4'd8) |-> (link_reg == RET_REG));

  // Return address is the following instruction; the PC then leaves it.
  assert_link_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_val == pc_o + 32'd4));

endmodule

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic [3:0]  kind;
  logic [31:0] op_a, op_b, imm_ext;
  logic [25:0] jidx;
  logic [4:0]  rd_sel;
  logic [31:0] pc_o;
  logic        link_we;
  logic [4:0]  link_reg;
  logic [31:0] link_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [31:0] exp_pc;

  always #2.5 clk = ~clk;

  npc_unit #(.BOOT_ADDR(BOOT), .LINK_REG(31)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .kind(kind), .op_a(op_a), .op_b(op_b),
    .imm_ext(imm_ext), .jidx(jidx), .rd_sel(rd_sel), .pc_o(pc_o),
    .link_we(link_we), .link_reg(link_reg), .link_val(link_val)
  );

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd1, 4'd2:             return "R4";
      4'd3, 4'd4, 4'd5, 4'd6: return "R5";
      4'd7:                   return "R7";
      4'd8:                   return "R8";
      4'd9:                   return "R9";
      4'd10:                  return "R10";
      default:                return "R3";
    endcase
  endfunction

  function automatic logic cond_model(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) > 0;
      4'd4: return $signed(a) >= 0;
      4'd5: return $signed(a) < 0;
      4'd6: return $signed(a) <= 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] next_model(input logic [31:0] pc, input logic [3:0] k,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] imm, input logic [25:0] j);
    logic [31:0] nx;
    nx = pc + 32'd4;
    if (k >= 4'd1 && k <= 4'd6)
      return cond_model(k, a, b) ? nx + imm * 32'd4 : nx;
    if (k == 4'd7 || k == 4'd8) return {nx[31:28], j, 2'b00};
    if (k == 4'd9 || k == 4'd10) return a & 32'hFFFF_FFFC;
    return nx;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negative edge: drive, check link, pass one rising edge, check PC.
  task automatic step(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] imm, input logic [25:0] j, input logic [4:0] rd,
                      input logic e);
    logic [31:0] nx;
    logic        call;
    string       rq;
    kind = k; op_a = a; op_b = b; imm_ext = imm; jidx = j; rd_sel = rd; en = e;
    rq   = e ? req_of(k) : "R2";
    call = e && (k == 4'd8 || k == 4'd10);
    nx   = e ? next_model(exp_pc, k, a, b, imm, j) : exp_pc;
    #1;
    check(call ? rq : "R11", "link_we", {31'd0, link_we}, {31'd0, call});
    if (call) begin
      check(rq, "link_reg", {27'd0, link_reg}, (k == 4'd8) ? 32'd31 : {27'd0, rd});
      check(rq, "link_val", link_val, exp_pc + 32'd4);
    end
    @(negedge clk);
    check((e && k >= 4'd1 && k <= 4'd6) ? "R6" : rq, "pc", pc_o, nx);
    exp_pc = nx;
  endtask

  initial begin
    logic [31:0] bases [4];
    logic [31:0] avals [5];
    logic [31:0] imms  [4];
    logic [25:0] idxs  [3];
    bases = '{32'h0000_0100, 32'hEFFF_FFFC, 32'h7FFF_FFF0, 32'hFFFF_FFFC};
    avals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5677};
    imms  = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'hFFFF_8000};
    idxs  = '{26'h0, 26'h3FF_FFFF, 26'h155_5555};

    rst_n = 1'b0; en = 1'b0; kind = '0; op_a = '0; op_b = '0;
    imm_ext = '0; jidx = '0; rd_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset pc", pc_o, BOOT);
    exp_pc = BOOT;
    rst_n = 1'b1;

    // R3 from boot, then R2 stall with a call code present
    step(4'd0, '0, '0, '0, '0, '0, 1'b1);
    step(4'd8, '0, '0, '0, 26'h0AB_CDEF, 5'd7, 1'b0);
    step(4'd10, 32'h40, '0, '0, '0, 5'd9, 1'b0);

    for (int bi = 0; bi < 4; bi++) begin
      for (int k = 0; k < 16; k++) begin
        for (int ai = 0; ai < 5; ai++) begin
          for (int bj = 0; bj < 5; bj += 2) begin
            for (int ii = 0; ii < 4; ii++) begin
              step(4'd9, bases[bi], '0, '0, '0, '0, 1'b1);
              step(4'(k), avals[ai], (bj == 0) ? avals[ai] : avals[bj], imms[ii],
                   idxs[(ai + ii) % 3], 5'(ai * 6 + ii + 1), 1'b1);
            end
          end
        end
      end
    end

    // R9 misaligned register target, R10 call to register 0 path
    step(4'd9, 32'h1234_5677, '0, '0, '0, '0, 1'b1);
    step(4'd10, 32'h0000_2003, '0, '0, '0, 5'd0, 1'b1);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule